// File: doc/BRIEF.md
# Configuration Image Write Port

This block is a single write-only data register on a lightweight AXI4-Lite style slave. A host writes configuration image words to it, four image bytes per write. The host packs them little-endian, so the first byte of the stream sits in bits [7:0]. The block buffers one word and forwards it to a configuration bus through a valid/ready handshake. Every read of the port fails with an error response and zero data. A write to any other offset also fails, and it leaves the buffered word alone.

The target can be in one of two modes. For a full configuration, the whole 32-bit word goes out as a single beat. That beat is released only while the target reports that it has entered its configuration phase. For a partial reconfiguration, the word goes out as two 16-bit beats, low half first. Each beat waits for the target's partial-ready flag on its own. The mode input is captured when a word is accepted, so the mode applies to each word as a whole.

While a word is still buffered, the port stalls further data writes by holding its write-ready signals low. A slow target therefore pushes back on the host, and no data is dropped.

Top module: `cfgwr_port`

## Requirements
- R1: After reset, bvalid, rvalid and cb_valid are 0, and awready/wready are 0 while no write is offered.
- R2: A write with awaddr equal to 0x000 into an empty buffer is accepted with awready and wready high in the same cycle. bvalid rises on the next clock edge with bresp = 2'b00 (OKAY).
- R3: A write to any other address is accepted and answered with bresp = 2'b10 (SLVERR). No cb beat results from it.
- R4: A read is accepted when arvalid is high and no read response is pending. rvalid rises on the next edge with rdata = 0 and rresp = 2'b10 (SLVERR), and it holds until rready.
- R5: In full mode (pr_mode = 0 at acceptance), the word goes out as one beat with cb_data equal to the written word and cb_half = 0. cb_valid is high only while cfg_phase is 1.
- R6: In partial mode (pr_mode = 1 at acceptance), the word goes out as two beats with cb_half = 1: first the written bits [15:0], then bits [31:16], each in cb_data[15:0] with cb_data[31:16] = 0. Each beat is offered only while pr_ready is 1.
- R7: While a word is buffered, a write to 0x000 is not accepted (awready = wready = 0). It completes after the buffered word's last beat, and no data is lost.
- R8: A change of pr_mode after a word is accepted does not change how that word is sent.
- R9: While cb_valid is high and cb_ready is low, cb_data does not change.
- R10: bvalid and bresp hold until bready. No new write is accepted while a write response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | 12 | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data, image bytes little-endian |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request ready |
| rvalid | output | 1 | Read response valid |
| rready | input | 1 | Read response ready |
| rdata | output | 32 | Read data, always zero |
| rresp | output | 2 | Read response code |
| pr_mode | input | 1 | 0 = full configuration, 1 = partial reconfiguration |
| cfg_phase | input | 1 | Target is in its configuration phase |
| pr_ready | input | 1 | Target ready for partial reconfiguration data |
| cb_valid | output | 1 | Configuration bus beat valid |
| cb_ready | input | 1 | Configuration bus beat accepted |
| cb_data | output | 32 | Configuration bus data |
| cb_half | output | 1 | Beat is a 16-bit transfer |

## Verification
On every cycle, the assertions check the readiness gating for each beat kind and the zero upper half of 16-bit beats. They also check that data is stable while a beat stalls, that write and read responses hold until taken, and that a data write is refused while a word is buffered. Other behaviours are visible only through the bench's scenarios: the order of the two half-words, the little-endian placement of the first image bytes, a mode change leaving a word in flight untouched, and a stalled write completing with its data intact once the buffer drains.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_PART = 1'b1
  } cfg_mode_e;

endpackage

// File: rtl/cfgwr_wr_front.sv
module cfgwr_wr_front
  import cfgwr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int DATA_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic              bready,
  input  logic              buf_free,
  output logic              awready,
  output logic              wready,
  output logic              bvalid,
  output logic [1:0]        bresp,
  output logic              load,
  output logic [DATA_W-1:0] load_data
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(DATA_OFFSET);

  logic       addr_hit;
  logic       accept;
  logic       bvalid_q, bvalid_d;
  logic [1:0] bresp_q, bresp_d;
  logic       bresp_en;

  // Both channels are taken together; a data write also needs buffer room.
  always_comb begin
    addr_hit = (awaddr == HIT_ADDR);
    accept   = awvalid & wvalid & ~bvalid_q & (~addr_hit | buf_free);
  end

  always_comb begin
    bvalid_d = bvalid_q;
    if (accept) begin
      bvalid_d = 1'b1;
    end else if (bready) begin
      bvalid_d = 1'b0;
    end
    bresp_en = accept;
    bresp_d  = addr_hit ? RESP_OKAY : RESP_SLVERR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
    end else begin
      bvalid_q <= bvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bresp_q <= RESP_OKAY;
    end else if (bresp_en) begin
      bresp_q <= bresp_d;
    end
  end

  assign awready   = accept;
  assign wready    = accept;
  assign bvalid    = bvalid_q;
  assign bresp     = bresp_q;
  assign load      = accept & addr_hit;
  assign load_data = wdata;

endmodule

// File: rtl/cfgwr_rd_front.sv
module cfgwr_rd_front
  import cfgwr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  input  logic              rready,
  output logic              arready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp
);

  logic              accept;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q;
  logic [1:0]        rresp_q;

  always_comb begin
    accept   = arvalid & ~rvalid_q;
    rvalid_d = rvalid_q;
    if (accept) begin
      rvalid_d = 1'b1;
    end else if (rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
    end
  end

  // The register is write-only: every read returns zero with an error.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rresp_q <= RESP_OKAY;
    end else if (accept) begin
      rdata_q <= '0;
      rresp_q <= RESP_SLVERR;
    end
  end

  assign arready = accept;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = rresp_q;

endmodule

// File: rtl/cfgwr_beat_mux.sv
module cfgwr_beat_mux
  import cfgwr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  cfg_mode_e         mode,
  input  logic              upper,
  output logic [DATA_W-1:0] beat
);

  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] half_sel;

  always_comb begin
    half_sel = upper ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
    if (mode == MODE_PART) begin
      beat = {{(DATA_W-HALF_W){1'b0}}, half_sel};
    end else begin
      beat = word;
    end
  end

endmodule

// File: rtl/cfgwr_feeder.sv
module cfgwr_feeder
  import cfgwr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  cfg_mode_e         load_mode,
  input  logic              cfg_phase,
  input  logic              pr_ready,
  input  logic              cb_ready,
  output logic              buf_free,
  output logic              cb_valid,
  output logic [DATA_W-1:0] cb_data,
  output logic              cb_half
);

  logic              full_q, full_d;
  logic              upper_q, upper_d;
  logic [DATA_W-1:0] word_q;
  cfg_mode_e         mode_q;
  logic              gate;
  logic              fire;
  logic              last_beat;

  // Readiness source follows the mode captured with the word.
  always_comb begin
    gate      = (mode_q == MODE_PART) ? pr_ready : cfg_phase;
    cb_valid  = full_q & gate;
    fire      = cb_valid & cb_ready;
    last_beat = (mode_q == MODE_FULL) | upper_q;
  end

  always_comb begin
    full_d  = full_q;
    upper_d = upper_q;
    if (load) begin
      full_d  = 1'b1;
      upper_d = 1'b0;
    end else if (fire) begin
      if (last_beat) begin
        full_d  = 1'b0;
        upper_d = 1'b0;
      end else begin
        upper_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      upper_q <= 1'b0;
    end else begin
      full_q  <= full_d;
      upper_q <= upper_d;
    end
  end

  // Word and mode load only on acceptance (clock enable = load).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= MODE_FULL;
    end else if (load) begin
      word_q <= load_data;
      mode_q <= load_mode;
    end
  end

  cfgwr_beat_mux #(.DATA_W(DATA_W)) u_mux (
    .word  (word_q),
    .mode  (mode_q),
    .upper (upper_q),
    .beat  (cb_data)
  );

  assign cb_half  = (mode_q == MODE_PART);
  assign buf_free = ~full_q;

endmodule

// File: rtl/cfgwr_port.sv
module cfgwr_port
  import cfgwr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int DATA_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  input  logic              pr_mode,
  input  logic              cfg_phase,
  input  logic              pr_ready,
  output logic              cb_valid,
  input  logic              cb_ready,
  output logic [DATA_W-1:0] cb_data,
  output logic              cb_half
);

  logic              buf_free;
  logic              load;
  logic [DATA_W-1:0] load_data;
  cfg_mode_e         load_mode;

  assign load_mode = pr_mode ? MODE_PART : MODE_FULL;

  cfgwr_wr_front #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .DATA_OFFSET (DATA_OFFSET)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .awvalid   (awvalid),
    .awaddr    (awaddr),
    .wvalid    (wvalid),
    .wdata     (wdata),
    .bready    (bready),
    .buf_free  (buf_free),
    .awready   (awready),
    .wready    (wready),
    .bvalid    (bvalid),
    .bresp     (bresp),
    .load      (load),
    .load_data (load_data)
  );

  cfgwr_rd_front #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .arvalid (arvalid),
    .rready  (rready),
    .arready (arready),
    .rvalid  (rvalid),
    .rdata   (rdata),
    .rresp   (rresp)
  );

  cfgwr_feeder #(.DATA_W(DATA_W)) u_fd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .load_mode (load_mode),
    .cfg_phase (cfg_phase),
    .pr_ready  (pr_ready),
    .cb_ready  (cb_ready),
    .buf_free  (buf_free),
    .cb_valid  (cb_valid),
    .cb_data   (cb_data),
    .cb_half   (cb_half)
  );

endmodule

// File: rtl/cfgwr_port_chk.sv
module cfgwr_port_chk #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int DATA_OFFSET = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              awvalid,
  input logic              awready,
  input logic [ADDR_W-1:0] awaddr,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              arvalid,
  input logic              arready,
  input logic              rvalid,
  input logic              rready,
  input logic              cfg_phase,
  input logic              pr_ready,
  input logic              cb_valid,
  input logic              cb_ready,
  input logic [DATA_W-1:0] cb_data,
  input logic              cb_half
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(DATA_OFFSET);

  // Independent occupancy model built from port traffic only.
  logic occ_q;
  logic second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q    <= 1'b0;
      second_q <= 1'b0;
    end else begin
      if (awvalid && awready && awaddr == HIT_ADDR) begin
        occ_q    <= 1'b1;
        second_q <= 1'b0;
      end else if (cb_valid && cb_ready) begin
        if (!cb_half || second_q) begin
          occ_q    <= 1'b0;
          second_q <= 1'b0;
        end else begin
          second_q <= 1'b1;
        end
      end
    end
  end

  // R2
  wr_resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && awready) |=> bvalid);

  // R10
  wr_resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

  // R10
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready);

  // R4
  rd_resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arready) |=> rvalid);

  // R4
  rd_resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> rvalid);

  // R5
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && !cb_half) |-> cfg_phase);

  // R6
  part_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && cb_half) |-> pr_ready);

  // R6
  part_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && cb_half) |-> (cb_data[DATA_W-1:HALF_W] == '0));

  // R9
  beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && !cb_ready) |=> $stable(cb_data));

  // R7
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && awaddr == HIT_ADDR) |-> !awready);

endmodule

bind cfgwr_port cfgwr_port_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .DATA_OFFSET (DATA_OFFSET)
) u_chk (.*);

// File: tb/cfgwr_port_tb_top.sv
module cfgwr_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic        awvalid, awready;
  logic [11:0] awaddr;
  logic        wvalid, wready;
  logic [31:0] wdata;
  logic        bvalid, bready;
  logic [1:0]  bresp;
  logic        arvalid, arready, rvalid, rready;
  logic [31:0] rdata;
  logic [1:0]  rresp;
  logic        pr_mode, cfg_phase, pr_ready;
  logic        cb_valid, cb_ready, cb_half;
  logic [31:0] cb_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  cfgwr_port dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Offers one write; returns the response code and whether bvalid came.
  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          output logic [1:0] resp, output logic got_b);
    int n = 0;
    @(negedge clk);
    awvalid = 1; wvalid = 1; awaddr = a; wdata = d;
    #1;
    while (!awready && n < 60) begin
      @(negedge clk); #1; n++;
    end
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    #1;
    got_b = bvalid; resp = bresp;
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic get_beat(output logic [31:0] d, output logic h, output logic got);
    int n = 0;
    @(negedge clk);
    cb_ready = 1;
    #1;
    while (!cb_valid && n < 60) begin
      @(negedge clk); #1; n++;
    end
    got = cb_valid; d = cb_data; h = cb_half;
    @(posedge clk);
    @(negedge clk);
    cb_ready = 0;
  endtask

  typedef struct packed {
    logic        part;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 12'h000, 32'h0403_0201},
    '{1'b1, 12'h000, 32'h0403_0201},
    '{1'b0, 12'h004, 32'hDEAD_BEEF},
    '{1'b1, 12'h000, 32'hA5B6_C7D8},
    '{1'b0, 12'h000, 32'hFFFF_0000},
    '{1'b1, 12'hFFC, 32'h1234_5678}
  };

  initial begin
    logic [1:0]  rs;
    logic        gb, gh, gv;
    logic [31:0] bd, held;
    awvalid = 0; wvalid = 0; awaddr = '0; wdata = '0; bready = 0;
    arvalid = 0; rready = 0; pr_mode = 0; cfg_phase = 0; pr_ready = 0; cb_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!bvalid && !rvalid && !cb_valid && !awready && !wready, "R1 reset idle",
        {27'd0, bvalid, rvalid, cb_valid, awready, wready}, 32'd0);

    // Table walk
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      logic [1:0] er = (v.addr == 12'h000) ? 2'b00 : 2'b10;
      pr_mode = v.part; cfg_phase = 1; pr_ready = 1;
      do_write(v.addr, v.data, rs, gb);
      chk(gb && rs == er, (er == 2'b00) ? "R2 write response" : "R3 bad offset response",
          {29'd0, gb, rs}, {30'd1, er});
      if (er == 2'b00) begin
        if (!v.part) begin
          get_beat(bd, gh, gv);
          chk(gv && !gh && bd == v.data, "R5 full beat", bd, v.data);
        end else begin
          get_beat(bd, gh, gv);
          chk(gv && gh && bd == {16'd0, v.data[15:0]}, "R6 low half first", bd, {16'd0, v.data[15:0]});
          get_beat(bd, gh, gv);
          chk(gv && gh && bd == {16'd0, v.data[31:16]}, "R6 high half second", bd, {16'd0, v.data[31:16]});
        end
      end else begin
        @(negedge clk); cb_ready = 1;
        repeat (3) @(negedge clk);
        #1;
        chk(!cb_valid, "R3 no beat from bad offset", {31'd0, cb_valid}, 32'd0);
        cb_ready = 0;
      end
    end

    // R4 read
    @(negedge clk);
    arvalid = 1;
    #1;
    chk(arready, "R4 read accepted", {31'd0, arready}, 32'd1);
    @(negedge clk);
    arvalid = 0;
    #1;
    chk(rvalid && rdata == 0 && rresp == 2'b10, "R4 read error", {rdata[29:0], rresp}, {30'd0, 2'b10});
    @(negedge clk); #1;
    chk(rvalid, "R4 read response held", {31'd0, rvalid}, 32'd1);
    rready = 1;
    @(negedge clk); rready = 0; #1;
    chk(!rvalid, "R4 read response taken", {31'd0, rvalid}, 32'd0);

    // R5 gating plus R7 stall
    pr_mode = 0; cfg_phase = 0; cb_ready = 1;
    do_write(12'h000, 32'h1111_2222, rs, gb);
    repeat (3) @(negedge clk);
    #1;
    chk(!cb_valid, "R5 held before configuration phase", {31'd0, cb_valid}, 32'd0);
    cb_ready = 0;
    @(negedge clk);
    awvalid = 1; wvalid = 1; awaddr = 12'h000; wdata = 32'h3333_4444;
    repeat (4) @(negedge clk);
    #1;
    chk(!awready && !wready, "R7 write stalled while buffered", {30'd0, awready, wready}, 32'd0);
    cfg_phase = 1;
    get_beat(bd, gh, gv);
    chk(gv && bd == 32'h1111_2222, "R7 first word intact", bd, 32'h1111_2222);
    #1;
    chk(awready, "R7 stalled write proceeds", {31'd0, awready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    #1;
    // R10: response held while bready low, further write refused
    awvalid = 1; wvalid = 1; awaddr = 12'h008;
    #0.5;
    chk(bvalid && !awready, "R10 no accept while response pending", {30'd0, bvalid, awready}, 32'd2);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    #1;
    chk(bvalid && bresp == 2'b00, "R10 response held", {29'd0, bvalid, bresp}, 32'd4);
    bready = 1; @(negedge clk); bready = 0;
    get_beat(bd, gh, gv);
    chk(gv && bd == 32'h3333_4444, "R7 stalled word delivered", bd, 32'h3333_4444);

    // R6 per-beat gating, R9 hold, R8 mode change in flight
    pr_mode = 1; pr_ready = 0; cfg_phase = 1;
    do_write(12'h000, 32'hCAFE_F00D, rs, gb);
    pr_mode = 0;
    cb_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(!cb_valid, "R6 low half waits for pr_ready", {31'd0, cb_valid}, 32'd0);
    cb_ready = 0;
    pr_ready = 1;
    @(negedge clk); #1;
    held = cb_data;
    repeat (2) @(negedge clk);
    #1;
    chk(cb_valid && cb_data == held, "R9 data held while stalled", cb_data, held);
    chk(cb_half && cb_data == 32'h0000_F00D, "R8 mode kept after change", cb_data, 32'h0000_F00D);
    cb_ready = 1;
    @(negedge clk);
    cb_ready = 0; pr_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!cb_valid, "R6 high half waits for pr_ready", {31'd0, cb_valid}, 32'd0);
    pr_ready = 1;
    get_beat(bd, gh, gv);
    chk(gv && gh && bd == 32'h0000_CAFE, "R8 R6 high half", bd, 32'h0000_CAFE);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule